// File: doc/BRIEF.md
# Indirect PHY Register Handshake Master

This block lets a host reach 16-bit PHY configuration registers that have no memory mapping. The PHY is reached only through one control word, which the block drives, and one status word, which it samples. For every access the block runs a chain of four-phase handshakes. In each step it presents a value with a strobe, waits for the PHY acknowledge to rise, withdraws the strobe and waits for the acknowledge to fall. Every wait polls the acknowledge at a fixed spacing and stops after a bounded number of polls.

The host pulses `start_i` with an address, a read/write select and write data. Every access begins with an address-capture step. A read then runs a read-strobe step, which samples the returned data. A write runs a data-capture step and then a commit step. When the access finishes, `done_o` pulses for one cycle. `err_o` is set with it if any wait ran out of polls.

The sequencer has these states. IDLE accepts a start and goes to ADDR_SET. ADDR_SET is one cycle and goes to ADDR_CAP. ADDR_CAP waits for ack high and goes to ADDR_REL. ADDR_REL waits for ack low. For a read it goes to RD_REQ, and for a write it goes to DAT_SET. RD_REQ waits for ack high, captures data and goes to RD_REL. RD_REL waits for ack low and returns to IDLE with done. DAT_SET is one cycle and goes to DAT_CAP. DAT_CAP waits for ack high and goes to DAT_REL. DAT_REL waits for ack low and goes to WR_REQ. WR_REQ waits for ack high and goes to WR_REL. WR_REL waits for ack low and goes to WR_FIN. WR_FIN is one cycle and returns to IDLE with done. From any waiting state, a poll budget that runs out leads straight to IDLE with done and error.

Top module: `phy_hs_master`

## Requirements
- R1: While reset is held, and in the first cycle after it, the control word, `done_o`, `err_o` and `rdata_o` are all zero.
- R2: Control word layout: bits [15:0] carry the address or data. Bit 16 is the address-capture strobe, bit 17 the data-capture strobe, bit 18 the write strobe and bit 19 the read strobe. At most one strobe is set at any time. Status word layout: bits [15:0] carry read data and bit 16 is the acknowledge. A write lands at the address the host gave.
- R3: The address step drives the address alone for one cycle. It then adds the address-capture strobe and waits for ack high. It then drives the address without the strobe and waits for ack low.
- R4: A read follows the address step. It drives only the read strobe and waits for ack high. On the poll that sees ack high it captures status bits [15:0]. It then drives the control word to zero and waits for ack low.
- R5: A write follows the address step with a data step. It drives the data alone for one cycle, then the data with the data-capture strobe, and waits for ack high. It then drives the data alone and waits for ack low.
- R6: The write ends with a commit step. It drives only the write strobe and waits for ack high, then drives the data alone and waits for ack low. It then drives the control word to zero for one cycle before finishing.
- R7: In a waiting state the acknowledge is polled once every POLL_GAP cycles. The first poll falls in the POLL_GAP-th cycle of the state, and a matching poll moves to the next state at that edge.
- R8: If MAX_POLLS polls in one wait all miss, the control word goes to zero, `done_o` and `err_o` pulse together, and the block returns to IDLE. The access is abandoned.
- R9: A start that arrives while an access is in progress is ignored. It causes no extra access and no extra done.
- R10: `rdata_o` changes only on the capturing poll of a read. Writes, failed accesses and ignored starts leave it unchanged.
- R11: `done_o` is high for exactly one cycle per accepted access, in the cycle the block is back in IDLE, with the control word zero. `err_o` is high only together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, taken only in IDLE |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | PHY register address |
| wdata_i | input | 16 | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Set with done when a wait ran out of polls |
| rdata_o | output | 16 | Last captured read data, held |
| phy_ctrl_o | output | 20 | Control word to the PHY |
| phy_stat_i | input | 17 | Status word from the PHY |

## Verification
The bench chases acknowledge timing at both edges of the poll budget. A reply that arrives on the very last poll must still succeed. A design that counts one poll too few would report a false timeout there. A design that counts one too many would hold the strobe a poll longer than the budget when the PHY is silent. A PHY that raises ack but never drops it tests the fall-side wait. A design that only timed out rising waits would hang in ADDR_REL. Read data is offered only while the read strobe is up, and a filler value is shown otherwise. Capturing one cycle late, or letting a write or failure disturb the held data, therefore shows up as a wrong `rdata_o`. A second start fired mid-access would, on a design that re-accepts it, produce an extra done and a stray write in the PHY model.

// File: rtl/phy_hs_pkg.sv
package phy_hs_pkg;

    // Sequencer states; order follows the handshake chain.
    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR_SET,
        S_ADDR_CAP,
        S_ADDR_REL,
        S_RD_REQ,
        S_RD_REL,
        S_DAT_SET,
        S_DAT_CAP,
        S_DAT_REL,
        S_WR_REQ,
        S_WR_REL,
        S_WR_FIN
    } hs_state_e;

    // Strobe positions above the data field, relative to its width.
    localparam int STB_CAP_ADDR = 0;
    localparam int STB_CAP_DATA = 1;
    localparam int STB_WRITE    = 2;
    localparam int STB_READ     = 3;
    localparam int STB_COUNT    = 4;

    // True for states that poll the acknowledge.
    function automatic logic st_polls(hs_state_e s);
        unique case (s)
            S_ADDR_CAP, S_ADDR_REL, S_RD_REQ, S_RD_REL,
            S_DAT_CAP, S_DAT_REL, S_WR_REQ, S_WR_REL: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Acknowledge level a polling state waits for.
    function automatic logic st_want(hs_state_e s);
        unique case (s)
            S_ADDR_CAP, S_RD_REQ, S_DAT_CAP, S_WR_REQ: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/phy_hs_poll.sv
// Poll pacing and retry budget for one waiting state.
module phy_hs_poll #(
    parameter int POLL_GAP  = 4,
    parameter int MAX_POLLS = 10
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    input  logic polling_i,
    input  logic ack_i,
    input  logic want_i,
    output logic hit_o,
    output logic quit_o
);

    localparam int GAP_W = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
    localparam int CNT_W = $clog2(MAX_POLLS + 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(POLL_GAP - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_POLLS - 1);

    logic [GAP_W-1:0] gap_q, gap_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             poll_now;
    logic             match;

    assign poll_now = polling_i && (gap_q == GAP_LAST);
    assign match    = (ack_i == want_i);
    assign hit_o    = poll_now && match;
    assign quit_o   = poll_now && !match && (cnt_q == CNT_LAST);

    always_comb begin
        gap_d = gap_q;
        cnt_d = cnt_q;
        if (restart_i || !polling_i) begin
            gap_d = '0;
            cnt_d = '0;
        end else if (poll_now) begin
            gap_d = '0;
            if (!match) begin
                cnt_d = cnt_q + 1'b1;
            end
        end else begin
            gap_d = gap_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gap_q <= '0;
            cnt_q <= '0;
        end else begin
            gap_q <= gap_d;
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/phy_hs_regs.sv
// Request latch and host-side result registers.
module phy_hs_regs #(
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              accept_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] phy_rd_i,
    input  logic              finish_i,
    input  logic              fail_i,
    output logic              is_wr_o,
    output logic [DATA_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o,
    output logic              err_o
);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            is_wr_o <= 1'b0;
            addr_o  <= '0;
            wdata_o <= '0;
        end else if (accept_i) begin
            is_wr_o <= we_i;
            addr_o  <= addr_i;
            wdata_o <= wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_o <= '0;
        end else if (capture_i) begin
            rdata_o <= phy_rd_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            done_o <= finish_i || fail_i;
            err_o  <= fail_i;
        end
    end

endmodule

// File: rtl/phy_hs_seq.sv
// Handshake sequencer: state register, next-state logic, control word.
module phy_hs_seq
    import phy_hs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CTL_W  = DATA_W + STB_COUNT
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              is_wr_i,
    input  logic [DATA_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              hit_i,
    input  logic              quit_i,
    output logic              restart_o,
    output logic              polling_o,
    output logic              want_o,
    output logic              accept_o,
    output logic              capture_o,
    output logic              finish_o,
    output logic              fail_o,
    output logic [CTL_W-1:0]  ctrl_o
);

    localparam int B_CA = DATA_W + STB_CAP_ADDR;
    localparam int B_CD = DATA_W + STB_CAP_DATA;
    localparam int B_WR = DATA_W + STB_WRITE;
    localparam int B_RD = DATA_W + STB_READ;

    hs_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (quit_i) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:     if (start_i) state_d = S_ADDR_SET;
                S_ADDR_SET: state_d = S_ADDR_CAP;
                S_ADDR_CAP: if (hit_i) state_d = S_ADDR_REL;
                S_ADDR_REL: if (hit_i) state_d = is_wr_i ? S_DAT_SET : S_RD_REQ;
                S_RD_REQ:   if (hit_i) state_d = S_RD_REL;
                S_RD_REL:   if (hit_i) state_d = S_IDLE;
                S_DAT_SET:  state_d = S_DAT_CAP;
                S_DAT_CAP:  if (hit_i) state_d = S_DAT_REL;
                S_DAT_REL:  if (hit_i) state_d = S_WR_REQ;
                S_WR_REQ:   if (hit_i) state_d = S_WR_REL;
                S_WR_REL:   if (hit_i) state_d = S_WR_FIN;
                S_WR_FIN:   state_d = S_IDLE;
                default:    state_d = S_IDLE;
            endcase
        end
    end

    assign restart_o = (state_d != state_q);
    assign polling_o = st_polls(state_q);
    assign want_o    = st_want(state_q);
    assign accept_o  = (state_q == S_IDLE) && start_i;
    assign capture_o = (state_q == S_RD_REQ) && hit_i;
    assign finish_o  = ((state_q == S_RD_REL) && hit_i) || (state_q == S_WR_FIN);
    assign fail_o    = quit_i;

    // Control word, decoded from the state
    always_comb begin
        ctrl_o = '0;
        unique case (state_q)
            S_ADDR_SET, S_ADDR_REL: begin
                ctrl_o[DATA_W-1:0] = addr_i;
            end
            S_ADDR_CAP: begin
                ctrl_o[DATA_W-1:0] = addr_i;
                ctrl_o[B_CA]       = 1'b1;
            end
            S_RD_REQ: begin
                ctrl_o[B_RD] = 1'b1;
            end
            S_DAT_SET, S_DAT_REL, S_WR_REL: begin
                ctrl_o[DATA_W-1:0] = wdata_i;
            end
            S_DAT_CAP: begin
                ctrl_o[DATA_W-1:0] = wdata_i;
                ctrl_o[B_CD]       = 1'b1;
            end
            S_WR_REQ: begin
                ctrl_o[B_WR] = 1'b1;
            end
            S_IDLE, S_RD_REL, S_WR_FIN: begin
                ctrl_o = '0;
            end
            default: begin
                ctrl_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/phy_hs_master.sv
module phy_hs_master #(
    parameter int DATA_W    = 16,
    parameter int POLL_GAP  = 4,
    parameter int MAX_POLLS = 10
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic                 we_i,
    input  logic [DATA_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic                 done_o,
    output logic                 err_o,
    output logic [DATA_W-1:0]    rdata_o,
    output logic [DATA_W+3:0]    phy_ctrl_o,
    input  logic [DATA_W:0]      phy_stat_i
);

    localparam int CTL_W = DATA_W + phy_hs_pkg::STB_COUNT;

    logic              restart, polling, want, hit, quit;
    logic              accept, capture, finish, fail;
    logic              is_wr;
    logic [DATA_W-1:0] addr_q, wdata_q;
    logic [CTL_W-1:0]  ctrl;

    phy_hs_seq #(.DATA_W(DATA_W), .CTL_W(CTL_W)) u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start_i),
        .is_wr_i   (is_wr),
        .addr_i    (addr_q),
        .wdata_i   (wdata_q),
        .hit_i     (hit),
        .quit_i    (quit),
        .restart_o (restart),
        .polling_o (polling),
        .want_o    (want),
        .accept_o  (accept),
        .capture_o (capture),
        .finish_o  (finish),
        .fail_o    (fail),
        .ctrl_o    (ctrl)
    );

    phy_hs_poll #(.POLL_GAP(POLL_GAP), .MAX_POLLS(MAX_POLLS)) u_poll (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart),
        .polling_i (polling),
        .ack_i     (phy_stat_i[DATA_W]),
        .want_i    (want),
        .hit_o     (hit),
        .quit_o    (quit)
    );

    phy_hs_regs #(.DATA_W(DATA_W)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .accept_i  (accept),
        .we_i      (we_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .capture_i (capture),
        .phy_rd_i  (phy_stat_i[DATA_W-1:0]),
        .finish_i  (finish),
        .fail_i    (fail),
        .is_wr_o   (is_wr),
        .addr_o    (addr_q),
        .wdata_o   (wdata_q),
        .rdata_o   (rdata_o),
        .done_o    (done_o),
        .err_o     (err_o)
    );

    assign phy_ctrl_o = ctrl;

endmodule

// File: rtl/phy_hs_master_chk.sv
module phy_hs_master_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              done_o,
    input logic              err_o,
    input logic [DATA_W-1:0] rdata_o,
    input logic [DATA_W+3:0] phy_ctrl_o,
    input logic              ack_i
);

    localparam int B_CA = DATA_W;
    localparam int B_CD = DATA_W + 1;
    localparam int B_WR = DATA_W + 2;
    localparam int B_RD = DATA_W + 3;

    p_one_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(phy_ctrl_o[DATA_W+3:DATA_W]));

    p_addr_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(phy_ctrl_o[B_CA]) |-> $past(phy_ctrl_o[DATA_W-1:0]) == phy_ctrl_o[DATA_W-1:0]);

    p_addr_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(phy_ctrl_o[B_CA]) |-> ($past(ack_i) || done_o));

    p_rd_after_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(phy_ctrl_o[B_RD]) |-> !$past(ack_i));

    p_data_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(phy_ctrl_o[B_CD]) |-> $past(phy_ctrl_o[DATA_W-1:0]) == phy_ctrl_o[DATA_W-1:0]);

    p_wr_after_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(phy_ctrl_o[B_WR]) |-> !$past(ack_i));

    p_done_ctrl_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (phy_ctrl_o == '0));

    p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(rdata_o) |-> $past(phy_ctrl_o[B_RD]));

    p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_err_with_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> done_o);

endmodule

bind phy_hs_master phy_hs_master_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_o     (done_o),
    .err_o      (err_o),
    .rdata_o    (rdata_o),
    .phy_ctrl_o (phy_ctrl_o),
    .ack_i      (phy_stat_i[DATA_W])
);

// File: tb/phy_hs_master_tb.sv
module phy_hs_master_tb;

    localparam int GAP  = 4;
    localparam int MAXP = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        we = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        done, err;
    logic [15:0] rdata;
    logic [19:0] ctrl;
    logic [16:0] stat;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    phy_hs_master #(.DATA_W(16), .POLL_GAP(GAP), .MAX_POLLS(MAXP)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .we_i(we),
        .addr_i(addr), .wdata_i(wdata), .done_o(done), .err_o(err),
        .rdata_o(rdata), .phy_ctrl_o(ctrl), .phy_stat_i(stat)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- PHY model ----------------
    int          phy_lat = 1;
    int          phy_mode = 0;   // 0 normal, 1 never acks, 2 never releases
    int          phy_cnt = 0;
    logic        phy_ack = 1'b0;
    logic [15:0] phy_a = '0, phy_d = '0, phy_rd = 16'hdead;
    logic [19:0] phy_prev = '0;
    logic [15:0] mem [16];

    assign stat = {phy_ack, phy_rd};

    initial for (int i = 0; i < 16; i++) mem[i] = 16'h0;

    always @(negedge clk) begin
        logic strobes, target;
        strobes = |ctrl[19:16];
        target = (phy_mode == 1) ? 1'b0 : (phy_mode == 2) ? (phy_ack | strobes) : strobes;
        if (target != phy_ack) begin
            if (phy_cnt >= phy_lat) begin phy_ack = target; phy_cnt = 0; end
            else phy_cnt++;
        end else phy_cnt = 0;
        if (ctrl[16] && !phy_prev[16]) phy_a = ctrl[15:0];
        if (ctrl[17] && !phy_prev[17]) phy_d = ctrl[15:0];
        if (ctrl[18] && !phy_prev[18]) mem[phy_a[3:0]] = phy_d;
        phy_rd = ctrl[19] ? mem[phy_a[3:0]] : 16'hdead;
        phy_prev = ctrl;
    end

    // ---------------- Reference model ----------------
    typedef struct {
        logic [19:0] word;
        bit          waits;
        bit          want;
        bit          cap;
        int          req;
    } step_t;

    step_t q[$];
    logic [19:0] exp_ctrl = '0;
    logic        exp_done = 1'b0, exp_err = 1'b0;
    logic [15:0] exp_rdata = '0;
    int          exp_req = 1;
    int          m_gap = 0, m_polls = 0;

    function automatic step_t mk(logic [19:0] w, bit wt, bit wa, bit c, int r);
        step_t s;
        s.word = w; s.waits = wt; s.want = wa; s.cap = c; s.req = r;
        return s;
    endfunction

    always @(posedge clk) begin
        bit adv;
        if (!rst_n) begin
            q.delete();
            exp_ctrl = '0; exp_done = 0; exp_err = 0; exp_rdata = '0;
            m_gap = 0; m_polls = 0; exp_req = 1;
        end else begin
            exp_done = 0; exp_err = 0; adv = 0;
            if (q.size() == 0) begin
                if (start) begin
                    q.push_back(mk({4'h0, addr}, 0, 0, 0, 3));
                    q.push_back(mk({4'h1, addr}, 1, 1, 0, 3));
                    q.push_back(mk({4'h0, addr}, 1, 0, 0, 3));
                    if (!we) begin
                        q.push_back(mk({4'h8, 16'h0}, 1, 1, 1, 4));
                        q.push_back(mk(20'h0, 1, 0, 0, 4));
                    end else begin
                        q.push_back(mk({4'h0, wdata}, 0, 0, 0, 5));
                        q.push_back(mk({4'h2, wdata}, 1, 1, 0, 5));
                        q.push_back(mk({4'h0, wdata}, 1, 0, 0, 5));
                        q.push_back(mk({4'h4, 16'h0}, 1, 1, 0, 6));
                        q.push_back(mk({4'h0, wdata}, 1, 0, 0, 6));
                        q.push_back(mk(20'h0, 0, 0, 0, 6));
                    end
                    exp_ctrl = q[0].word; exp_req = q[0].req;
                    m_gap = 0; m_polls = 0;
                end
            end else begin
                if (!q[0].waits) adv = 1;
                else if (m_gap == GAP - 1) begin   // R7 poll spacing
                    m_gap = 0;
                    if (stat[16] == q[0].want) begin
                        if (q[0].cap) exp_rdata = stat[15:0];
                        adv = 1;
                    end else begin
                        m_polls++;
                        if (m_polls == MAXP) begin
                            q.delete();
                            exp_ctrl = '0; exp_done = 1; exp_err = 1; exp_req = 8;
                        end
                    end
                end else m_gap++;
                if (adv) begin
                    void'(q.pop_front());
                    m_gap = 0; m_polls = 0;
                    if (q.size() == 0) begin
                        exp_ctrl = '0; exp_done = 1; exp_req = 11;
                    end else begin
                        exp_ctrl = q[0].word; exp_req = q[0].req;
                    end
                end
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(ctrl == exp_ctrl, $sformatf("R%0d/R7 control word", exp_req), 32'(ctrl), 32'(exp_ctrl));
            chk(done == exp_done, "R11 done", 32'(done), 32'(exp_done));
            chk(err == exp_err, "R8 err", 32'(err), 32'(exp_err));
            chk(rdata == exp_rdata, "R10 rdata", 32'(rdata), 32'(exp_rdata));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    // ---------------- Stimulus ----------------
    task automatic wait_done(output bit e, output logic [15:0] r);
        int k;
        k = 0;
        while (!done && k < 3000) begin @(negedge clk); k++; end
        chk(done == 1'b1, "R11 done reached", 32'(done), 32'd1);
        e = err; r = rdata;
        @(negedge clk);
    endtask

    task automatic txn(input bit wr, input logic [15:0] a, input logic [15:0] d,
                       output bit e, output logic [15:0] r);
        @(negedge clk);
        start = 1; we = wr; addr = a; wdata = d;
        @(negedge clk);
        start = 0;
        wait_done(e, r);
    endtask

    task automatic settle();
        phy_mode = 0; phy_lat = 1;
        repeat (20) @(negedge clk);
    endtask

    initial begin
        bit          e;
        logic [15:0] r;
        int          extra;

        repeat (3) @(negedge clk);
        // R1: reset values
        chk(ctrl == 0, "R1 ctrl in reset", 32'(ctrl), 0);
        chk({done, err} == 0, "R1 done/err in reset", 32'({done, err}), 0);
        chk(rdata == 0, "R1 rdata in reset", 32'(rdata), 0);
        rst_n = 1;
        @(negedge clk);
        chk(ctrl == 0 && !done, "R1 after reset", 32'(ctrl), 0);

        // R5 R6 R2: write, short latency
        phy_lat = 1;
        txn(1, 16'h1005, 16'h00a5, e, r);
        chk(e == 0, "R6 write ok", 32'(e), 0);
        chk(mem[5] == 16'h00a5, "R2 written data", 32'(mem[5]), 32'h00a5);
        chk(phy_a == 16'h1005, "R2 captured address", 32'(phy_a), 32'h1005);
        chk(r == 16'h0, "R10 write leaves rdata", 32'(r), 0);

        // R4: read back, longer latency
        phy_lat = 3;
        txn(0, 16'h1005, 16'h0, e, r);
        chk(e == 0, "R4 read ok", 32'(e), 0);
        chk(r == 16'h00a5, "R4 read data", 32'(r), 32'h00a5);

        // zero-latency write and read
        phy_lat = 0;
        txn(1, 16'h100d, 16'hbeef, e, r);
        txn(0, 16'h100d, 16'h0, e, r);
        chk(r == 16'hbeef, "R4 read data lat0", 32'(r), 32'hbeef);

        // R9: second start during a read is ignored
        phy_lat = 2;
        @(negedge clk);
        start = 1; we = 0; addr = 16'h1005;
        @(negedge clk);
        start = 0;
        repeat (6) @(negedge clk);
        start = 1; we = 1; addr = 16'h1003; wdata = 16'h5555;
        @(negedge clk);
        start = 0;
        wait_done(e, r);
        chk(r == 16'h00a5, "R9 first access completes", 32'(r), 32'h00a5);
        extra = 0;
        repeat (60) begin if (done) extra++; @(negedge clk); end
        chk(extra == 0, "R9 no extra done", 32'(extra), 0);
        chk(mem[3] == 16'h0, "R9 no stray write", 32'(mem[3]), 0);

        // R7: reply on a late but in-budget poll
        phy_lat = 30;
        txn(0, 16'h100d, 16'h0, e, r);
        chk(e == 0, "R7 late reply accepted", 32'(e), 0);
        chk(r == 16'hbeef, "R7 late reply data", 32'(r), 32'hbeef);

        // R8: reply beyond the budget
        phy_lat = 60;
        txn(1, 16'h1001, 16'h1234, e, r);
        chk(e == 1, "R8 slow reply times out", 32'(e), 1);
        chk(mem[1] == 16'h0, "R8 abandoned write", 32'(mem[1]), 0);
        settle();

        // R8: PHY silent
        phy_mode = 1;
        txn(0, 16'h1005, 16'h0, e, r);
        chk(e == 1, "R8 no ack", 32'(e), 1);
        chk(r == 16'hbeef, "R10 rdata kept on failure", 32'(r), 32'hbeef);
        settle();

        // R8: ack never falls
        phy_mode = 2;
        txn(1, 16'h1002, 16'h7777, e, r);
        chk(e == 1, "R8 ack stuck high", 32'(e), 1);
        settle();

        // recovery after failures
        txn(0, 16'h1005, 16'h0, e, r);
        chk(e == 0 && r == 16'h00a5, "R4 read after recovery", 32'(r), 32'h00a5);

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule